// File: doc/BRIEF.md
# Dual-Channel Loopback Serial Controller

This block is a two-channel serial peripheral that sits on an 8-bit processor I/O bus. Each channel has a data port and a control port. Bytes written to a channel's data port go into a one-byte holding register. Reading the same data port returns the held byte. No line transmitter or receiver is attached, so this loopback path is the only data path.

The control side is reached indirectly. A control write made while the register pointer is zero loads a new pointer into register 0. The next control access then reaches the selected register, and after that the pointer returns to zero. Register 0 reads back a status byte built from the holding state and from two configuration bits in register 5. Register 1 reads back a second status byte that carries a sticky overrun flag. Register 2 on channel B holds the interrupt vector, which both channels share.

Bus transfers are single-cycle strobes. Read data appears in the cycle after the read strobe and lasts for that one cycle only.

Top module: `dsl_serial_top`

## Requirements
- R1: After reset, both pointers, holding flags, overrun flags, configuration bits and the vector are zero. A status read of either channel returns 0x04. Register 1 and the vector read back 0x00.
- R2: Address 0xFC is the data port of channel A and 0xFE is the data port of channel B. Address 0xFD is the control port of channel A and 0xFF is the control port of channel B. Address bit 1 selects the channel and bit 0 selects control. Any other address changes no state and reads back 0x00.
- R3: A control write while the pointer is zero loads bits 2:0 of the byte as the pointer. The next control read or write reaches the register that pointer selects, and afterwards the pointer is zero. Registers 3, 4, 6 and 7 read back 0x00.
- R4: The register 0 read value is as follows. Bit 5 is bit 1 of the last byte written to register 5. Bit 3 is bit 7 of that byte. Bit 0 is 1 when a byte is held. Bit 2 is 1 when no byte is held. All other bits are 0.
- R5: A data write stores the byte and marks it held. If a byte was already held, the overrun flag is set.
- R6: A data read while a byte is held returns that byte and clears the held mark. A data read with nothing held returns 0x00.
- R7: Register 1 reads back the overrun flag in bit 5 (0x20), with all other bits 0. The flag stays set through data reads and is cleared only by a write to register 1.
- R8: A write to register 2 on channel B loads the shared vector, and a read of register 2 on channel B returns it. On channel A, register 2 reads back 0x00, and a write to it leaves the vector unchanged.
- R9: Read data is valid for exactly the one cycle after the edge that samples the read strobe. In every other cycle, `rdata` is 0x00.
- R10: When read and write strobes are both high, only the write takes effect and the read data of that access is 0x00.
- R11: The two channels keep separate pointers, holding registers, overrun flags and configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | I/O address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Read data, valid the cycle after the read strobe |

## Verification
All state changes take effect on the edge that samples a strobe. A read therefore returns its byte exactly one cycle later, and any side effect of that read is visible to the next access. The bench drives each strobe for one cycle from the falling edge. Every read pushes its expected byte into a queue. A monitor pops an entry on the falling edge that follows the sampling edge, which is the only cycle in which R9 allows data. The expected value of the combined read-and-write access is 0x00, which checks R10 in the same slot.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int PTR_W   = 3;
    localparam int NUM_CH  = 2;
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    localparam logic [ADDR_W-1:0] PORT_BASE = 8'hFC;

    localparam logic [PTR_W-1:0] REG_PTR   = 3'd0;
    localparam logic [PTR_W-1:0] REG_STAT1 = 3'd1;
    localparam logic [PTR_W-1:0] REG_VEC   = 3'd2;
    localparam logic [PTR_W-1:0] REG_CFG   = 3'd5;

    localparam int CFG_LO_BIT = 1;
    localparam int CFG_HI_BIT = 7;
    localparam int OVR_BIT    = 5;

    typedef struct packed {
        logic            hit;
        logic            is_ctrl;
        logic [CH_W-1:0] ch;
    } dsl_sel_t;

    function automatic logic [DATA_W-1:0] make_status0(
        input logic cfg_lo, input logic cfg_hi, input logic held);
        logic [DATA_W-1:0] s;
        s    = '0;
        s[5] = cfg_lo;
        s[3] = cfg_hi;
        s[2] = ~held;
        s[0] = held;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] make_status1(input logic ovr);
        logic [DATA_W-1:0] s;
        s          = '0;
        s[OVR_BIT] = ovr;
        return s;
    endfunction
endpackage

// File: rtl/dsl_decode.sv
module dsl_decode
    import dsl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dsl_sel_t          sel
);
    localparam int LOW_BITS = 1 + CH_W;

    always_comb begin
        sel.hit     = (addr[ADDR_W-1:LOW_BITS] == PORT_BASE[ADDR_W-1:LOW_BITS]);
        sel.is_ctrl = addr[0];
        sel.ch      = addr[LOW_BITS-1:1];
    end
endmodule

// File: rtl/dsl_channel.sv
module dsl_channel
    import dsl_pkg::*;
#(
    parameter bit OWNS_VECTOR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              is_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] vector_in,
    output logic [DATA_W-1:0] rd_val,
    output logic              vec_ld
);
    logic [PTR_W-1:0]  ptr_q;
    logic              cfg_lo_q, cfg_hi_q;
    logic              ovr_q;
    logic              held_q;
    logic [DATA_W-1:0] hold_q;

    logic ctrl_wr, ctrl_rd, data_wr, data_rd;

    always_comb begin
        ctrl_wr = acc_wr &  is_ctrl;
        ctrl_rd = acc_rd &  is_ctrl;
        data_wr = acc_wr & ~is_ctrl;
        data_rd = acc_rd & ~is_ctrl;
        vec_ld  = OWNS_VECTOR && ctrl_wr && (ptr_q == REG_VEC);
    end

    always_comb begin
        rd_val = '0;
        if (is_ctrl) begin
            case (ptr_q)
                REG_PTR:   rd_val = make_status0(cfg_lo_q, cfg_hi_q, held_q);
                REG_STAT1: rd_val = make_status1(ovr_q);
                REG_VEC:   rd_val = OWNS_VECTOR ? vector_in : '0;
                default:   rd_val = '0;
            endcase
        end else if (held_q) begin
            rd_val = hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            cfg_lo_q <= 1'b0;
            cfg_hi_q <= 1'b0;
            ovr_q    <= 1'b0;
            held_q   <= 1'b0;
            hold_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                case (ptr_q)
                    REG_PTR:   ptr_q <= wdata[PTR_W-1:0];
                    REG_STAT1: ovr_q <= 1'b0;
                    REG_CFG: begin
                        cfg_lo_q <= wdata[CFG_LO_BIT];
                        cfg_hi_q <= wdata[CFG_HI_BIT];
                    end
                    default: ;
                endcase
                if (ptr_q != REG_PTR) ptr_q <= '0;
            end
            if (ctrl_rd) ptr_q <= '0;
            if (data_wr) begin
                if (held_q) ovr_q <= 1'b1;
                held_q <= 1'b1;
                hold_q <= wdata;
            end
            if (data_rd) held_q <= 1'b0;
        end
    end

    AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_wr || ctrl_rd) && ptr_q != REG_PTR) |=> (ptr_q == REG_PTR)); // R3
    AST_HELD_SET: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> held_q); // R5
    AST_OVR_ON_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (data_wr && held_q) |=> ovr_q); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !(ctrl_wr && ptr_q == REG_STAT1)) |=> ovr_q); // R7
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> !held_q); // R6
endmodule

// File: rtl/dsl_serial_top.sv
module dsl_serial_top
    import dsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    output logic [DATA_W-1:0] rdata
);
    dsl_sel_t          sel;
    logic [DATA_W-1:0] vector_q;
    logic [DATA_W-1:0] ch_val [NUM_CH];
    logic [NUM_CH-1:0] vec_ld;
    logic              rd_only;

    dsl_decode u_decode (
        .addr (addr),
        .sel  (sel)
    );

    assign rd_only = rd & ~wr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic mine;
        assign mine = sel.hit && (sel.ch == CH_W'(g));
        dsl_channel #(
            .OWNS_VECTOR (g == NUM_CH - 1)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .acc_rd    (mine & rd_only),
            .acc_wr    (mine & wr),
            .is_ctrl   (sel.is_ctrl),
            .wdata     (wdata),
            .vector_in (vector_q),
            .rd_val    (ch_val[g]),
            .vec_ld    (vec_ld[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vector_q <= '0;
            rdata    <= '0;
        end else begin
            if (|vec_ld) vector_q <= wdata;
            rdata <= (rd_only && sel.hit) ? ch_val[sel.ch] : '0;
        end
    end

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata == '0)); // R9
    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
        (rd && wr) |=> (rdata == '0)); // R10
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel.hit && sel.is_ctrl) |=> $stable(vector_q)); // R8
    AST_ONE_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec_ld)); // R8
endmodule

// File: tb/dsl_serial_top_tb.sv
`timescale 1ns/1ps
module dsl_serial_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t exp_q[$];
    logic rd_d = 1'b0;

    always #4 clk = ~clk;

    dsl_serial_top u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .rd(rd), .wr(wr), .rdata(rdata)
    );

    always @(posedge clk) rd_d <= rd;

    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (rdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h expected=%02h", e.tag, rdata, e.exp);
            end
        end
    end

    task automatic wr_cyc(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_cyc(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        addr = a; rd = 1'b1; wr = 1'b0;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic both_cyc(input logic [7:0] a, input logic [7:0] d, input string tag);
        exp_t it;
        @(negedge clk);
        it.exp = 8'h00; it.tag = tag;
        exp_q.push_back(it);
        addr = a; wdata = d; rd = 1'b1; wr = 1'b1;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_cyc(8'hFD, 8'h04, "R1 status A");
        rd_cyc(8'hFF, 8'h04, "R1 status B");
        wr_cyc(8'hFD, 8'h01);
        rd_cyc(8'hFD, 8'h00, "R1 reg1 A");
        wr_cyc(8'hFF, 8'h02);
        rd_cyc(8'hFF, 8'h00, "R1 vector");
        // R4 status layout from register 5
        wr_cyc(8'hFD, 8'h05);
        wr_cyc(8'hFD, 8'h82);
        rd_cyc(8'hFD, 8'h2C, "R4 cfg bits empty");
        wr_cyc(8'hFC, 8'h5A);
        rd_cyc(8'hFD, 8'h29, "R4 cfg bits held");
        // R6 take and empty read
        rd_cyc(8'hFC, 8'h5A, "R6 take byte");
        rd_cyc(8'hFC, 8'h00, "R6 empty read");
        rd_cyc(8'hFD, 8'h2C, "R6 held cleared");
        // R5 / R7 overrun on channel B
        wr_cyc(8'hFE, 8'h11);
        wr_cyc(8'hFE, 8'h22);
        wr_cyc(8'hFF, 8'h01);
        rd_cyc(8'hFF, 8'h20, "R5 overrun set");
        rd_cyc(8'hFE, 8'h22, "R5 last byte kept");
        wr_cyc(8'hFF, 8'h01);
        rd_cyc(8'hFF, 8'h20, "R7 sticky after read");
        // R11 channel A unaffected
        wr_cyc(8'hFD, 8'h01);
        rd_cyc(8'hFD, 8'h00, "R11 A no overrun");
        rd_cyc(8'hFF, 8'h04, "R11 B cfg clear");
        // R7 clear by write to register 1
        wr_cyc(8'hFF, 8'h01);
        wr_cyc(8'hFF, 8'h00);
        wr_cyc(8'hFF, 8'h01);
        rd_cyc(8'hFF, 8'h00, "R7 cleared");
        // R3 pointer returns to zero, unused registers
        wr_cyc(8'hFD, 8'h01);
        rd_cyc(8'hFD, 8'h00, "R3 reg1 via pointer");
        rd_cyc(8'hFD, 8'h2C, "R3 pointer back to 0");
        wr_cyc(8'hFD, 8'h06);
        rd_cyc(8'hFD, 8'h00, "R3 reg6 zero");
        // R8 vector
        wr_cyc(8'hFF, 8'h02);
        wr_cyc(8'hFF, 8'hA7);
        wr_cyc(8'hFF, 8'h02);
        rd_cyc(8'hFF, 8'hA7, "R8 vector load");
        wr_cyc(8'hFD, 8'h02);
        wr_cyc(8'hFD, 8'h3C);
        wr_cyc(8'hFF, 8'h02);
        rd_cyc(8'hFF, 8'hA7, "R8 A write ignored");
        wr_cyc(8'hFD, 8'h02);
        rd_cyc(8'hFD, 8'h00, "R8 A reg2 zero");
        // R2 unmapped address ignored
        wr_cyc(8'hFB, 8'h99);
        wr_cyc(8'h7C, 8'h98);
        rd_cyc(8'hFB, 8'h00, "R2 unmapped read");
        rd_cyc(8'hFC, 8'h00, "R2 A data untouched");
        rd_cyc(8'hFE, 8'h00, "R2 B data untouched");
        rd_cyc(8'hFD, 8'h2C, "R2 A status untouched");
        // R10 simultaneous strobes
        both_cyc(8'hFC, 8'h33, "R10 read suppressed");
        rd_cyc(8'hFC, 8'h33, "R10 write taken");
        // R9 one-cycle data: sample the cycle after
        @(negedge clk);
        n_checks++;
        if (rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R9: rdata=%02h expected=00", rdata);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule